// File: doc/BRIEF.md
# Orbit Turn Counter and Inhibit Timer

This block derives orbit timing from the bunch-crossing clock. A free-running divider produces a local one-cycle orbit pulse once every 3564 crossings. The active orbit pulse is taken either from that divider or from one of three outside sources: the incoming trigger link, an external input or the pattern generator. Every active orbit advances a 4-bit turn counter, and an event-counter-reset clears it. A turn-match flag stays high for the whole turn whose count equals a programmed turn number.

Each orbit also starts a 12-bit timer. The timer drives a trigger/command inhibit window that is four crossings wide. The window position is written into a shadow register, and the shadow value is copied into the running timer only when an orbit arrives. This keeps a window from moving partway through a turn.

Settings are written through a small register port: a write strobe, a 2-bit address and a data word. Address 0 selects the orbit source, address 1 holds the inhibit position and address 2 holds the turn number. A write to address 3 has no effect.

Top module: `otc_orbit_turn_inhibit`

## Requirements
- R1: After reset the orbit source is the internal divider, the turn count is 0, the programmed turn number is 0 (so turn_match_o is high), the inhibit position is 0 and inhibit_o is low.
- R2: With the internal source selected, orbit_o is a one-cycle pulse in the cycle when the divider holds count 3563 (ORBIT_LEN-1). The first pulse comes in the 3563rd cycle after reset, and the pulses then repeat every 3564 cycles.
- R3: Writing address 0 sets the source from data bits [1:0]: 0 internal divider, 1 link, 2 external, 3 pattern generator. orbit_o follows the selected source in the same cycle, and the other sources are ignored.
- R4: turn_o increments by one modulo 16 in the cycle after each cycle in which orbit_o is high, and holds otherwise.
- R5: ecr_i high in a cycle makes turn_o 0 in the next cycle. This takes priority over an orbit in the same cycle.
- R6: If orbit_o is high in cycle n and the active position is P, inhibit_o is high in cycles n+1+P through n+4+P and low in the other cycles of that turn.
- R7: Writing address 1 loads data bits [11:0] into the shadow position. The active position changes only at the next orbit, so a window already scheduled for the current turn keeps its old position.
- R8: turn_match_o is high exactly while turn_o equals the turn number written at address 2 (data bits [3:0]).
- R9: inhibit_o stays low until the first orbit after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_orbit_i | input | 1 | Orbit pulse from the incoming trigger link |
| ext_orbit_i | input | 1 | Orbit pulse from an external input |
| pgen_orbit_i | input | 1 | Orbit pulse from the pattern generator |
| ecr_i | input | 1 | Event-counter-reset, clears the turn count |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | TIMER_W | Register write data |
| orbit_o | output | 1 | Selected orbit pulse |
| turn_o | output | TURN_W | Turn count |
| turn_match_o | output | 1 | Turn count equals the programmed turn number |
| inhibit_o | output | 1 | Trigger/command inhibit window |

## Verification
A wrong divider count shows up as orbit_o landing off cycle 3563 of the orbit. Because turn_o only moves on an orbit, a slipped pulse also shows a turn count that is early or late by one cycle at the boundary. A shadow position copied at the wrong moment moves inhibit_o within the same turn, so the bench rewrites the position just before a scheduled window and checks the first cycle of that window. A lost priority between reset and orbit leaves turn_o at 1 instead of 0 in the very next cycle. A bad source decode either misses an orbit edge in the same cycle or lets an unselected input advance the count.

// File: rtl/otc_pkg.sv
package otc_pkg;
   typedef enum logic [1:0] {
      SRC_LOCAL = 2'd0,
      SRC_LINK  = 2'd1,
      SRC_EXT   = 2'd2,
      SRC_PGEN  = 2'd3
   } orbit_src_e;

   localparam logic [1:0] REG_SRC  = 2'd0;
   localparam logic [1:0] REG_INH  = 2'd1;
   localparam logic [1:0] REG_TURN = 2'd2;
endpackage

// File: rtl/otc_orbit_div.sv
module otc_orbit_div #(
   parameter int unsigned ORBIT_LEN = 3564
) (
   input  logic clk,
   input  logic rst_n,
   output logic pulse_o
);
   localparam int unsigned CNT_W = $clog2(ORBIT_LEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ORBIT_LEN - 1);

   generate
      if (ORBIT_LEN < 2) begin : g_bad_len
         $error("otc_orbit_div: ORBIT_LEN must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                   cnt_q <= cnt_q + CNT_W'(1);
   end

   assign pulse_o = (cnt_q == LAST);
endmodule

// File: rtl/otc_turn_ctr.sv
module otc_turn_ctr #(
   parameter int unsigned TURN_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              orbit_i,
   input  logic              ecr_i,
   input  logic [TURN_W-1:0] turn_num_i,
   output logic [TURN_W-1:0] turn_o,
   output logic              match_o
);
   generate
      if (TURN_W < 1) begin : g_bad_w
         $error("otc_turn_ctr: TURN_W must be at least 1");
      end
   endgenerate

   logic [TURN_W-1:0] turn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       turn_q <= '0;
      else if (ecr_i)   turn_q <= '0;
      else if (orbit_i) turn_q <= turn_q + TURN_W'(1);
   end

   assign turn_o  = turn_q;
   assign match_o = (turn_q == turn_num_i);
endmodule

// File: rtl/otc_inhibit_timer.sv
module otc_inhibit_timer #(
   parameter int unsigned TIMER_W = 12,
   parameter int unsigned INH_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               orbit_i,
   input  logic               shadow_wr_i,
   input  logic [TIMER_W-1:0] shadow_data_i,
   output logic [TIMER_W-1:0] act_pos_o,
   output logic               inhibit_o
);
   localparam int unsigned EXT_W = TIMER_W + 1;
   localparam logic [EXT_W-1:0] SPAN = EXT_W'(INH_W - 1);

   generate
      if (INH_W < 1) begin : g_bad_inh
         $error("otc_inhibit_timer: INH_W must be at least 1");
      end
   endgenerate

   logic [TIMER_W-1:0] shadow_q, act_q, tmr_q;
   logic               run_q;
   logic [EXT_W-1:0]   win_end, tmr_ext, act_ext;

   assign act_ext = {1'b0, act_q};
   assign tmr_ext = {1'b0, tmr_q};
   assign win_end = act_ext + SPAN;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           shadow_q <= '0;
      else if (shadow_wr_i) shadow_q <= shadow_data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
         tmr_q <= '0;
         run_q <= 1'b0;
      end else if (orbit_i) begin
         act_q <= shadow_q;
         tmr_q <= '0;
         run_q <= 1'b1;
      end else if (run_q) begin
         if (tmr_ext == win_end || tmr_q == '1) run_q <= 1'b0;
         else                                 tmr_q <= tmr_q + TIMER_W'(1);
      end
   end

   assign act_pos_o = act_q;
   assign inhibit_o = run_q && (tmr_ext >= act_ext) && (tmr_ext <= win_end);
endmodule

// File: rtl/otc_orbit_turn_inhibit.sv
module otc_orbit_turn_inhibit #(
   parameter int unsigned ORBIT_LEN = 3564,
   parameter int unsigned TURN_W    = 4,
   parameter int unsigned TIMER_W   = 12,
   parameter int unsigned INH_W     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               link_orbit_i,
   input  logic               ext_orbit_i,
   input  logic               pgen_orbit_i,
   input  logic               ecr_i,
   input  logic               cfg_wr_i,
   input  logic [1:0]         cfg_addr_i,
   input  logic [TIMER_W-1:0] cfg_wdata_i,
   output logic               orbit_o,
   output logic [TURN_W-1:0]  turn_o,
   output logic               turn_match_o,
   output logic               inhibit_o
);
   import otc_pkg::*;

   localparam int unsigned SRC_W = 2;

   generate
      if (TIMER_W < TURN_W || TIMER_W < SRC_W) begin : g_bad_data_w
         $error("otc_orbit_turn_inhibit: TIMER_W too narrow for the register fields");
      end
   endgenerate

   orbit_src_e         src_q;
   logic [TURN_W-1:0]  turn_sel_q;
   logic               loc_orbit;
   logic [TIMER_W-1:0] act_pos;
   logic               shadow_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q      <= SRC_LOCAL;
         turn_sel_q <= '0;
      end else if (cfg_wr_i) begin
         if (cfg_addr_i == REG_SRC)  src_q      <= orbit_src_e'(cfg_wdata_i[SRC_W-1:0]);
         if (cfg_addr_i == REG_TURN) turn_sel_q <= cfg_wdata_i[TURN_W-1:0];
      end
   end

   assign shadow_wr = cfg_wr_i && (cfg_addr_i == REG_INH);

   otc_orbit_div #(.ORBIT_LEN(ORBIT_LEN)) div_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pulse_o (loc_orbit)
   );

   always_comb begin
      unique case (src_q)
         SRC_LINK: orbit_o = link_orbit_i;
         SRC_EXT:  orbit_o = ext_orbit_i;
         SRC_PGEN: orbit_o = pgen_orbit_i;
         default:  orbit_o = loc_orbit;
      endcase
   end

   otc_turn_ctr #(.TURN_W(TURN_W)) turn_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .orbit_i    (orbit_o),
      .ecr_i      (ecr_i),
      .turn_num_i (turn_sel_q),
      .turn_o     (turn_o),
      .match_o    (turn_match_o)
   );

   otc_inhibit_timer #(.TIMER_W(TIMER_W), .INH_W(INH_W)) inh_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .orbit_i       (orbit_o),
      .shadow_wr_i   (shadow_wr),
      .shadow_data_i (cfg_wdata_i),
      .act_pos_o     (act_pos),
      .inhibit_o     (inhibit_o)
   );
endmodule

// File: rtl/otc_checker.sv
module otc_checker #(
   parameter int unsigned ORBIT_LEN = 3564,
   parameter int unsigned TURN_W    = 4,
   parameter int unsigned TIMER_W   = 12,
   parameter int unsigned INH_W     = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               loc_orbit,
   input logic               orbit_o,
   input logic               ecr_i,
   input logic [TURN_W-1:0]  turn_o,
   input logic               inhibit_o,
   input logic [TIMER_W-1:0] act_pos
);
   localparam int unsigned GAP_W = $clog2(ORBIT_LEN) + 1;
   localparam int unsigned HI_W  = $clog2(INH_W + 2) + 1;

   logic [GAP_W-1:0] gap_q;
   logic [HI_W-1:0]  hi_q;
   logic             seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         hi_q   <= '0;
         seen_q <= 1'b0;
      end else begin
         gap_q <= loc_orbit ? '0 : gap_q + GAP_W'(1);
         if (orbit_o)        hi_q <= '0;
         else if (inhibit_o) hi_q <= hi_q + HI_W'(1);
         else                hi_q <= '0;
         if (orbit_o) seen_q <= 1'b1;
      end
   end

   assert_orbit_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
      loc_orbit |-> gap_q == GAP_W'(ORBIT_LEN - 1));

   assert_turn_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (orbit_o && !ecr_i) |=> turn_o == TURN_W'($past(turn_o) + 1'b1));

   assert_turn_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!orbit_o && !ecr_i) |=> $stable(turn_o));

   assert_ecr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ecr_i |=> turn_o == '0);

   assert_window_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit_o |-> hi_q < HI_W'(INH_W));

   assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !orbit_o |=> $stable(act_pos));

   assert_no_early_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> !inhibit_o);
endmodule

bind otc_orbit_turn_inhibit otc_checker #(
   .ORBIT_LEN (ORBIT_LEN),
   .TURN_W    (TURN_W),
   .TIMER_W   (TIMER_W),
   .INH_W     (INH_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .loc_orbit (loc_orbit),
   .orbit_o   (orbit_o),
   .ecr_i     (ecr_i),
   .turn_o    (turn_o),
   .inhibit_o (inhibit_o),
   .act_pos   (act_pos)
);

// File: tb/otc_orbit_turn_inhibit_tb_top.sv
`timescale 1ns/1ps
module otc_orbit_turn_inhibit_tb_top;
   localparam int TURN_W  = 4;
   localparam int TIMER_W = 12;
   localparam int K_ORBIT = 0, K_TURN = 1, K_MATCH = 2, K_INH = 3;

   typedef struct {
      int    cyc;
      int    kind;
      int    val;
      string req;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic link_orbit = 1'b0, ext_orbit = 1'b0, pgen_orbit = 1'b0, ecr = 1'b0;
   logic cfg_wr = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [TIMER_W-1:0] cfg_wdata = '0;
   logic orbit, match, inhibit;
   logic [TURN_W-1:0] turn;

   int   cyc = 0, checks = 0, fails = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   otc_orbit_turn_inhibit dut_i (
      .clk(clk), .rst_n(rst_n), .link_orbit_i(link_orbit), .ext_orbit_i(ext_orbit),
      .pgen_orbit_i(pgen_orbit), .ecr_i(ecr), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
      .cfg_wdata_i(cfg_wdata), .orbit_o(orbit), .turn_o(turn),
      .turn_match_o(match), .inhibit_o(inhibit)
   );

   function automatic int observe(int kind);
      case (kind)
         K_ORBIT: return int'(orbit);
         K_TURN:  return int'(turn);
         K_MATCH: return int'(match);
         default: return int'(inhibit);
      endcase
   endfunction

   task automatic check(string req, string what, int act, int exp_v);
      checks++;
      if (act != exp_v) begin
         fails++;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp_v);
      end
   endtask

   task automatic expect_at(int c, int kind, int val, string req);
      exp_t e;
      e.cyc = c; e.kind = kind; e.val = val; e.req = req;
      sb.push_back(e);
   endtask

   // monitor: pops scoreboard entries that fall due in the current cycle
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].cyc == cyc) begin
               check(sb[i].req, "output", observe(sb[i].kind), sb[i].val);
               sb.delete(i);
            end
         end
      end
   end

   task automatic wait_to(int c);
      while (cyc < c) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr(logic [1:0] a, int d);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = TIMER_W'(d);
      @(posedge clk); #1;
      cfg_wr = 1'b0;
   endtask

   task automatic pulse(int which);
      case (which)
         0: link_orbit = 1'b1;
         1: ext_orbit  = 1'b1;
         2: pgen_orbit = 1'b1;
         default: ecr  = 1'b1;
      endcase
      @(posedge clk); #1;
      link_orbit = 1'b0; ext_orbit = 1'b0; pgen_orbit = 1'b0; ecr = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired at cycle %0d: actual hung expected finish", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      #2;
      check("R1", "orbit in reset", int'(orbit), 0);
      check("R1", "turn in reset", int'(turn), 0);
      check("R1", "inhibit in reset", int'(inhibit), 0);
      check("R1", "match in reset", int'(match), 1);

      // expected items, computed from the requirements
      expect_at(5, K_MATCH, 0, "R8");
      expect_at(13, K_INH, 0, "R9");
      expect_at(3562, K_ORBIT, 0, "R2");
      expect_at(3563, K_ORBIT, 1, "R2");
      expect_at(3563, K_TURN, 0, "R4");
      expect_at(3564, K_ORBIT, 0, "R2");
      expect_at(3564, K_TURN, 1, "R4");
      expect_at(3564, K_MATCH, 0, "R8");
      expect_at(3573, K_INH, 0, "R6");
      expect_at(3574, K_INH, 1, "R7");
      expect_at(3577, K_INH, 1, "R6");
      expect_at(3578, K_INH, 0, "R6");
      expect_at(7127, K_ORBIT, 1, "R2");
      expect_at(7128, K_TURN, 2, "R4");
      expect_at(7128, K_MATCH, 1, "R8");
      expect_at(7138, K_INH, 0, "R7");
      expect_at(7228, K_INH, 1, "R7");
      expect_at(7231, K_INH, 1, "R6");
      expect_at(7232, K_INH, 0, "R6");
      expect_at(7300, K_TURN, 2, "R5");
      expect_at(7301, K_TURN, 0, "R5");
      expect_at(7301, K_MATCH, 0, "R8");
      expect_at(10691, K_ORBIT, 1, "R2");
      expect_at(10692, K_TURN, 0, "R5");
      expect_at(14255, K_ORBIT, 0, "R3");
      expect_at(14256, K_TURN, 0, "R3");
      expect_at(14300, K_ORBIT, 1, "R3");
      expect_at(14300, K_INH, 0, "R6");
      expect_at(14301, K_TURN, 1, "R3");
      expect_at(14301, K_INH, 1, "R6");
      expect_at(14304, K_INH, 1, "R6");
      expect_at(14305, K_INH, 0, "R6");
      expect_at(14400, K_ORBIT, 0, "R3");
      expect_at(14401, K_TURN, 1, "R3");
      expect_at(14420, K_ORBIT, 1, "R3");
      expect_at(14421, K_TURN, 2, "R3");
      expect_at(14421, K_MATCH, 1, "R8");
      expect_at(14441, K_TURN, 3, "R3");
      expect_at(14561, K_TURN, 15, "R4");
      expect_at(14571, K_TURN, 0, "R4");

      #1 rst_n = 1'b1;

      // driver
      wait_to(2);     wr(2'd1, 10);     // shadow position 10
      wr(2'd2, 2);                      // turn number 2
      wait_to(3572);  wr(2'd1, 100);    // rewrite just before the window
      wait_to(7300);  pulse(3);         // ECR alone
      wait_to(10691); pulse(3);         // ECR together with orbit
      wait_to(10700); wr(2'd0, 2);      // external source
      wait_to(10702); wr(2'd1, 0);
      wait_to(14300); pulse(1);
      wait_to(14400); pulse(0);         // link while external selected
      wait_to(14410); wr(2'd0, 1);      // link source
      wait_to(14420); pulse(0);
      wait_to(14430); wr(2'd0, 3);      // pattern generator source
      wait_to(14440); pulse(2);
      for (int i = 0; i < 13; i++) begin
         wait_to(14450 + 10 * i);
         pulse(2);
      end
      wait_to(14600);

      foreach (sb[i]) begin
         checks++; fails++;
         $display("FAIL %s item for cycle %0d: actual not observed expected %0d",
                  sb[i].req, sb[i].cyc, sb[i].val);
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule